// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Command Sequencer

This block sits on the controller side of an SDRAM interface. It owns the clock-enable and the three command strobes whenever the memory has to be refreshed or put into a low-power state. Requests for an auto refresh, for self-refresh entry and for power-down entry arrive as single-cycle pulses and are held until they are served. Exits from self-refresh and from power-down are level inputs that are only looked at while the matching mode is active. The block keeps one flag that records whether any row may still be open. A refresh or power-down entry made while that flag is set is preceded by a precharge of all banks and a wait of the precharge time.

Each timing wait (the row-cycle time after a refresh or a self-refresh exit, and the precharge time after a precharge-all) is a down-counter whose limit is a parameter. The same counter caps how long the clock enable may stay low in power-down, because the memory does not refresh itself in that mode. The access-ready output tells the normal read and write path that it may drive an access command at the next clock edge.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset the clock enable is high, the strobes show NOP (row, column and write strobes all high), the all-banks address bit is low and access-ready is high. Whenever access-ready is high, the clock enable is high and the strobes show NOP.
- R2: An auto-refresh request with no row open produces, on the second clock edge after the pulse, one cycle with the row and column strobes low, the write strobe high, the clock enable high and the all-banks bit low.
- R3: If a row was reported open, a refresh or power-down request first produces one precharge-all cycle (row strobe low, column strobe high, write strobe low, all-banks bit high). The refresh or power-down entry follows exactly T_RP cycles later, with NOP in between.
- R4: After an auto refresh the strobes stay at NOP and access-ready stays low. Access-ready rises T_RC-1 cycles after the refresh cycle. A second refresh that is already pending is issued exactly T_RC cycles after the first.
- R5: Self-refresh entry is one cycle with the row and column strobes low, the write strobe high and the clock enable low. The clock enable then stays low with NOP and access-ready low until exit.
- R6: The self-refresh exit input raises the clock enable at the next edge. Access-ready then rises T_RC-1 cycles after the first high cycle of the clock enable.
- R7: Power-down entry drops the clock enable with NOP on the strobes. Access-ready stays low while the clock enable is low.
- R8: The power-down exit input raises the clock enable at the next edge, and access-ready is high in that same cycle.
- R9: In power-down the clock enable stays low for at most PD_MAX consecutive cycles. After that the block raises it by itself.
- R10: When auto-refresh and power-down requests are pending together, the refresh is issued first. Power-down entry follows T_RC cycles later, and access-ready stays low throughout.
- R11: The self-refresh exit and power-down exit inputs have no effect when the block is idle: the clock enable stays high, the strobes stay NOP and access-ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_req | input | 1 | Pulse: request one auto refresh |
| sr_req | input | 1 | Pulse: request self-refresh entry |
| sr_exit | input | 1 | Level: leave self-refresh |
| pd_req | input | 1 | Pulse: request power-down entry |
| pd_exit | input | 1 | Level: leave power-down |
| row_opened | input | 1 | Pulse: the access path opened a row |
| clk_en_o | output | 1 | Memory clock enable |
| row_strobe_n | output | 1 | Row address strobe, active low |
| col_strobe_n | output | 1 | Column address strobe, active low |
| wr_en_n | output | 1 | Write enable strobe, active low |
| ap_all | output | 1 | Address bit that selects all banks, high only on precharge-all |
| acc_ready | output | 1 | An access command may be driven at the next edge |

## Verification
A wrong wait-counter value shows up directly at the pins. The second refresh, the power-down entry after a precharge, or the rise of access-ready lands one or more cycles away from the count the requirements give, so every timing test compares exact cycle offsets. A stale row-open flag shows within two edges of a request, either as a missing precharge-all cycle or as an extra one. A state machine stuck in a low-power state shows as a clock enable that stays low past PD_MAX cycles or never returns after an exit input.

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq #(
  parameter int T_RC   = 8,
  parameter int T_RP   = 3,
  parameter int PD_MAX = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ar_req,
  input  logic sr_req,
  input  logic sr_exit,
  input  logic pd_req,
  input  logic pd_exit,
  input  logic row_opened,
  output logic clk_en_o,
  output logic row_strobe_n,
  output logic col_strobe_n,
  output logic wr_en_n,
  output logic ap_all,
  output logic acc_ready
);
  localparam int MX1  = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int MAXC = (MX1 > PD_MAX) ? MX1 : PD_MAX;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RC_LD  = CW'(T_RC - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
  localparam logic [CW-1:0] PD_END = CW'(PD_MAX - 1);
  localparam logic [CW-1:0] PD_LIM = CW'(PD_MAX);

  typedef enum logic [2:0] {S_IDLE, S_PREW, S_RCW, S_SREF, S_PDN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          ar_p, sr_p, pd_p, open_q;

  wire any_p = ar_p | sr_p | pd_p;
  wire nop   = row_strobe_n & col_strobe_n & wr_en_n;

  assign acc_ready = (st == S_IDLE) & ~(any_p | ar_req | sr_req | pd_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      ar_p         <= 1'b0;
      sr_p         <= 1'b0;
      pd_p         <= 1'b0;
      open_q       <= 1'b0;
      clk_en_o     <= 1'b1;
      row_strobe_n <= 1'b1;
      col_strobe_n <= 1'b1;
      wr_en_n      <= 1'b1;
      ap_all       <= 1'b0;
    end else begin
      row_strobe_n <= 1'b1;
      col_strobe_n <= 1'b1;
      wr_en_n      <= 1'b1;
      ap_all       <= 1'b0;
      ar_p         <= ar_p | ar_req;
      sr_p         <= sr_p | sr_req;
      pd_p         <= pd_p | pd_req;
      open_q       <= open_q | row_opened;
      case (st)
        S_IDLE: if (any_p) begin
          if (open_q) begin
            row_strobe_n <= 1'b0;
            wr_en_n      <= 1'b0;
            ap_all       <= 1'b1;
            open_q       <= row_opened;
            cnt          <= RP_LD;
            st           <= S_PREW;
          end else if (ar_p) begin
            row_strobe_n <= 1'b0;
            col_strobe_n <= 1'b0;
            ar_p         <= ar_req;
            cnt          <= RC_LD;
            st           <= S_RCW;
          end else if (sr_p) begin
            row_strobe_n <= 1'b0;
            col_strobe_n <= 1'b0;
            clk_en_o     <= 1'b0;
            sr_p         <= sr_req;
            st           <= S_SREF;
          end else begin
            clk_en_o <= 1'b0;
            pd_p     <= pd_req;
            cnt      <= '0;
            st       <= S_PDN;
          end
        end
        S_PREW, S_RCW: begin
          if (cnt <= CW'(1)) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_SREF: if (sr_exit) begin
          clk_en_o <= 1'b1;
          cnt      <= RC_LD;
          st       <= S_RCW;
        end
        S_PDN: begin
          if (pd_exit || ar_p || sr_p || cnt == PD_END) begin
            clk_en_o <= 1'b1;
            st       <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire ref_cmd = ~row_strobe_n & ~col_strobe_n & wr_en_n;
  wire pre_cmd = ~row_strobe_n & col_strobe_n & ~wr_en_n;

  a_r1_ready_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> (clk_en_o && nop));

  a_r3_refresh_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> !$past(open_q));

  a_r3_precharge_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cmd |=> (nop && !acc_ready));

  a_r4_rc_gap_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd && clk_en_o) |=> (nop && !acc_ready));

  a_r5_low_power_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_o && !$fell(clk_en_o)) |-> (nop && !acc_ready));

  a_r9_dwell_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PDN) |-> (cnt < PD_LIM));
endmodule

// File: tb/tb_sdram_lp_seq.sv
module tb_sdram_lp_seq;
  localparam int T_RC = 5, T_RP = 3, PD_MAX = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ar_req = 0, sr_req = 0, sr_exit = 0, pd_req = 0, pd_exit = 0, row_opened = 0;
  logic clk_en_o, row_strobe_n, col_strobe_n, wr_en_n, ap_all, acc_ready;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_lp_seq #(.T_RC(T_RC), .T_RP(T_RP), .PD_MAX(PD_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .ar_req(ar_req), .sr_req(sr_req), .sr_exit(sr_exit),
    .pd_req(pd_req), .pd_exit(pd_exit), .row_opened(row_opened),
    .clk_en_o(clk_en_o), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
    .wr_en_n(wr_en_n), .ap_all(ap_all), .acc_ready(acc_ready));

  function automatic bit is_nop();
    return row_strobe_n && col_strobe_n && wr_en_n;
  endfunction
  function automatic bit is_ref();
    return !row_strobe_n && !col_strobe_n && wr_en_n;
  endfunction
  function automatic bit is_pre();
    return !row_strobe_n && col_strobe_n && !wr_en_n && ap_all;
  endfunction
  function automatic int pins();
    return {clk_en_o, row_strobe_n, col_strobe_n, wr_en_n, ap_all, acc_ready};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && !acc_ready; i++) step();
  endtask

  task automatic t_reset();
    chk(clk_en_o && is_nop() && !ap_all && acc_ready, "R1 reset pins", pins(), 6'b111101);
  endtask

  task automatic t_autoref();
    ar_req = 1; step(); ar_req = 0;
    step();
    chk(is_ref() && clk_en_o && !ap_all, "R2 auto refresh encoding", pins(), 6'b100100);
    for (int i = 1; i < T_RC - 1; i++) begin
      step();
      chk(is_nop() && !acc_ready, "R4 nop and not ready in tRC", pins(), 6'b111100);
    end
    step();
    chk(acc_ready, "R4 ready rises at T_RC-1", acc_ready, 1);
  endtask

  task automatic t_back_to_back();
    int n;
    ar_req = 1; step();
    step();
    chk(is_ref(), "R4 first refresh", pins(), 6'b100100);
    ar_req = 1; step(); ar_req = 0;
    n = 1;
    while (!is_ref() && n < 50) begin
      chk(!acc_ready, "R4 ready low with refresh pending", acc_ready, 0);
      step(); n++;
    end
    chk(n == T_RC, "R4 refresh spacing", n, T_RC);
    wait_ready();
  endtask

  task automatic t_open_ref();
    int n;
    row_opened = 1; ar_req = 1; step(); row_opened = 0; ar_req = 0;
    step();
    chk(is_pre(), "R3 precharge-all first", pins(), 6'b101010);
    n = 0;
    while (!is_ref() && n < 50) begin step(); n++; end
    chk(n == T_RP, "R3 refresh T_RP after precharge", n, T_RP);
    wait_ready();
  endtask

  task automatic t_sref();
    int n;
    sr_req = 1; step(); sr_req = 0;
    step();
    chk(is_ref() && !clk_en_o, "R5 self-refresh entry encoding", pins(), 6'b000100);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(!clk_en_o && is_nop() && !acc_ready, "R5 held in self refresh", pins(), 6'b011100);
    end
    sr_exit = 1; step(); sr_exit = 0;
    chk(clk_en_o && is_nop() && !acc_ready, "R6 clock enable back high", pins(), 6'b111100);
    n = 0;
    while (!acc_ready && n < 50) begin step(); n++; end
    chk(n == T_RC - 1, "R6 ready after exit", n, T_RC - 1);
  endtask

  task automatic t_pd();
    int n;
    row_opened = 1; pd_req = 1; step(); row_opened = 0; pd_req = 0;
    step();
    chk(is_pre(), "R3 precharge before power-down", pins(), 6'b101010);
    n = 0;
    while (clk_en_o && n < 50) begin step(); n++; end
    chk(n == T_RP, "R3 power-down T_RP after precharge", n, T_RP);
    chk(is_nop() && !acc_ready, "R7 power-down entry nop", pins(), 6'b011100);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!clk_en_o && !acc_ready, "R7 held in power-down", pins(), 6'b011100);
    end
    pd_exit = 1; step(); pd_exit = 0;
    chk(clk_en_o && acc_ready && is_nop(), "R8 one-clock exit", pins(), 6'b111101);
  endtask

  task automatic t_dwell();
    int n;
    pd_req = 1; step(); pd_req = 0;
    step();
    n = 0;
    while (!clk_en_o && n < 100) begin n++; step(); end
    chk(n == PD_MAX, "R9 forced exit after PD_MAX", n, PD_MAX);
    chk(acc_ready, "R9 ready after forced exit", acc_ready, 1);
  endtask

  task automatic t_prio();
    int n;
    ar_req = 1; pd_req = 1; step(); ar_req = 0; pd_req = 0;
    step();
    chk(is_ref() && clk_en_o, "R10 refresh served first", pins(), 6'b100100);
    n = 0;
    while (clk_en_o && n < 50) begin
      chk(!acc_ready, "R10 ready low while pending", acc_ready, 0);
      step(); n++;
    end
    chk(n == T_RC, "R10 power-down T_RC after refresh", n, T_RC);
    pd_exit = 1; step(); pd_exit = 0;
    wait_ready();
  endtask

  task automatic t_ignore();
    sr_exit = 1; pd_exit = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(clk_en_o && is_nop() && acc_ready, "R11 exits ignored when idle", pins(), 6'b111101);
    end
    sr_exit = 0; pd_exit = 0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_autoref();
    step();
    t_back_to_back();
    t_open_ref();
    t_sref();
    t_pd();
    t_dwell();
    t_prio();
    t_ignore();
    t_reset();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule